// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory array and produces the two mailbox interrupts that let each side signal the other. The two highest locations of the address space act as doorbells. When the left port finishes a write to the highest location, the interrupt toward the right port goes low. When the right port finishes a write to the location just below it, the interrupt toward the left port goes low. Each receiver acknowledges by reading its own doorbell location, and that read returns its interrupt to high.

The block only watches the access strobes and addresses of both ports. The data word written to a doorbell is stored by the memory array, not here. A port whose busy input is low has lost address arbitration, so its accesses neither raise nor clear a flag. All inputs are sampled on one clock, and the two flags are registered.

Top module: `mbx_int_top`

## Requirements
- R1: A write by the left port (ce low, rw_n low = write) to the all-ones address drives int_r_n low on the clock edge at which the write ends. The write ends when ce goes high, rw_n goes high or the address changes.
- R2: A read by the right port (ce low, rw_n high = read, oe low) of the all-ones address drives int_r_n high on the clock edge that samples that read.
- R3: A write by the right port to the all-ones-except-bit-0 address drives int_l_n low on the clock edge at which the write ends.
- R4: A read by the left port of the all-ones-except-bit-0 address, with ce and oe low, drives int_l_n high on the clock edge that samples it.
- R5: A write or a read whose port has busy_n low makes no change to either flag. For a write, the busy level that counts is the one in the last sampled cycle of the write.
- R6: While a qualifying write is still held active, its flag does not change.
- R7: If a flag is set and cleared on the same edge, it ends low (set wins).
- R8: While rst_n is low, both int_l_n and int_r_n are high, and they stay high after reset until an event sets them.
- R9: No other access changes a flag. This covers other addresses, the wrong port using a doorbell address, and a read with oe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_l_n | input | 1 | Left chip enable, active low |
| rw_l_n | input | 1 | Left read (1) / write (0) |
| oe_l_n | input | 1 | Left output enable, active low |
| busy_l_n | input | 1 | Left busy status, active low |
| addr_l | input | AW | Left address |
| ce_r_n | input | 1 | Right chip enable, active low |
| rw_r_n | input | 1 | Right read (1) / write (0) |
| oe_r_n | input | 1 | Right output enable, active low |
| busy_r_n | input | 1 | Right busy status, active low |
| addr_r | input | AW | Right address |
| int_l_n | output | 1 | Interrupt toward left port, active low |
| int_r_n | output | 1 | Interrupt toward right port, active low |

## Verification
The main function is driven with four kinds of access: writes and reads from each port to each doorbell address, the same accesses with the port's busy low, accesses to an ordinary address, and reads with output enable high. Together these separate the correct port/address pairing from a swapped one, and show that busy gating and the output-enable qualifier are both in force. Held writes show that a flag changes only when the write ends, not when it starts. A write that ends on the same edge as a clearing read shows which of the two wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef struct packed {
      logic ce_n;
      logic rw_n;
      logic oe_n;
      logic busy_n;
   } port_ctl_t;

   localparam int NUM_PORTS = 2;

   function automatic int peer_of(input int p);
      return (p == 0) ? 1 : 0;
   endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int           AW           = 15,
   parameter logic [AW-1:0] WR_ADDR     = '1,
   parameter logic [AW-1:0] RD_ADDR     = '1,
   parameter bit           CLR_NEEDS_OE = 1'b1
) (
   input  port_ctl_t        ctl,
   input  logic [AW-1:0]    addr,
   output logic             wr_hit,
   output logic             rd_clr
);
   logic rd_strobe;

   assign wr_hit = !ctl.ce_n && !ctl.rw_n && (addr == WR_ADDR);

   generate
      if (CLR_NEEDS_OE) begin : g_oe
         assign rd_strobe = !ctl.ce_n && ctl.rw_n && !ctl.oe_n;
      end else begin : g_no_oe
         assign rd_strobe = !ctl.ce_n && ctl.rw_n;
      end
   endgenerate

   assign rd_clr = rd_strobe && ctl.busy_n && (addr == RD_ADDR);
endmodule

// File: rtl/mbx_wr_track.sv
module mbx_wr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic busy_n,
   output logic set_pulse
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= wr_hit && busy_n;
   end

   assign set_pulse = armed_q && !wr_hit;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_n <= 1'b1;
      else if (set_i) flag_n <= 1'b0;
      else if (clr_i) flag_n <= 1'b1;
   end
endmodule

// File: rtl/mbx_int_top.sv
module mbx_int_top
   import mbx_pkg::*;
#(
   parameter int AW           = 15,
   parameter bit CLR_NEEDS_OE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_l_n,
   input  logic          rw_l_n,
   input  logic          oe_l_n,
   input  logic          busy_l_n,
   input  logic [AW-1:0] addr_l,
   input  logic          ce_r_n,
   input  logic          rw_r_n,
   input  logic          oe_r_n,
   input  logic          busy_r_n,
   input  logic [AW-1:0] addr_r,
   output logic          int_l_n,
   output logic          int_r_n
);
   localparam logic [AW-1:0] ADDR_TOP  = {AW{1'b1}};
   localparam logic [AW-1:0] ADDR_NEXT = {{(AW-1){1'b1}}, 1'b0};

   generate
      if (AW < 2) begin : g_bad_aw
         $error("mbx_int_top: AW must be at least 2");
      end
   endgenerate

   port_ctl_t             ctl    [NUM_PORTS];
   logic [AW-1:0]         addr   [NUM_PORTS];
   logic [NUM_PORTS-1:0]  wr_hit;
   logic [NUM_PORTS-1:0]  rd_clr;
   logic [NUM_PORTS-1:0]  set_p;
   logic [NUM_PORTS-1:0]  flag_n;

   assign ctl[0]  = '{ce_n: ce_l_n, rw_n: rw_l_n, oe_n: oe_l_n, busy_n: busy_l_n};
   assign ctl[1]  = '{ce_n: ce_r_n, rw_n: rw_r_n, oe_n: oe_r_n, busy_n: busy_r_n};
   assign addr[0] = addr_l;
   assign addr[1] = addr_r;

   // Port 0 (left) rings the top location and acknowledges the next one;
   // port 1 (right) does the reverse. Flag p is raised by port p.
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [AW-1:0] WR_A = (p == 0) ? ADDR_TOP  : ADDR_NEXT;
      localparam logic [AW-1:0] RD_A = (p == 0) ? ADDR_NEXT : ADDR_TOP;

      mbx_port_dec #(
         .AW(AW), .WR_ADDR(WR_A), .RD_ADDR(RD_A), .CLR_NEEDS_OE(CLR_NEEDS_OE)
      ) u_dec (
         .ctl(ctl[p]), .addr(addr[p]), .wr_hit(wr_hit[p]), .rd_clr(rd_clr[p])
      );

      mbx_wr_track u_trk (
         .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit[p]),
         .busy_n(ctl[p].busy_n), .set_pulse(set_p[p])
      );

      mbx_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set_i(set_p[p]),
         .clr_i(rd_clr[peer_of(p)]), .flag_n(flag_n[p])
      );
   end

   assign int_r_n = flag_n[0];
   assign int_l_n = flag_n[1];
endmodule

// File: rtl/mbx_int_chk.sv
module mbx_int_chk #(
   parameter int AW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_l_n,
   input logic          rw_l_n,
   input logic          oe_l_n,
   input logic          busy_l_n,
   input logic [AW-1:0] addr_l,
   input logic          ce_r_n,
   input logic          rw_r_n,
   input logic          oe_r_n,
   input logic          busy_r_n,
   input logic [AW-1:0] addr_r,
   input logic          int_l_n,
   input logic          int_r_n
);
   localparam logic [AW-1:0] TOP  = {AW{1'b1}};
   localparam logic [AW-1:0] NEXT = {{(AW-1){1'b1}}, 1'b0};

   logic lw_top, rw_next, rr_top, lr_next;
   assign lw_top  = !ce_l_n && !rw_l_n && addr_l == TOP;
   assign rw_next = !ce_r_n && !rw_r_n && addr_r == NEXT;
   assign rr_top  = !ce_r_n && rw_r_n && !oe_r_n && busy_r_n && addr_r == TOP;
   assign lr_next = !ce_l_n && rw_l_n && !oe_l_n && busy_l_n && addr_l == NEXT;

   AST_SET_INT_R: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lw_top && busy_l_n) && !lw_top) |=> !int_r_n); // R1
   AST_CLR_INT_R: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_top && !($past(lw_top && busy_l_n) && !lw_top)) |=> int_r_n); // R2
   AST_SET_INT_L: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rw_next && busy_r_n) && !rw_next) |=> !int_l_n); // R3
   AST_CLR_INT_L: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_next && !($past(rw_next && busy_r_n) && !rw_next)) |=> int_l_n); // R4
   AST_FALL_R_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_r_n) |-> $past(!lw_top && $past(lw_top && busy_l_n))); // R5
   AST_RISE_R_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_r_n) |-> $past(rr_top)); // R9
   AST_HOLD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lw_top) && lw_top && $past(int_r_n) && !rr_top) |-> int_r_n); // R6
endmodule

bind mbx_int_top mbx_int_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ce_l_n(ce_l_n), .rw_l_n(rw_l_n), .oe_l_n(oe_l_n), .busy_l_n(busy_l_n), .addr_l(addr_l),
   .ce_r_n(ce_r_n), .rw_r_n(rw_r_n), .oe_r_n(oe_r_n), .busy_r_n(busy_r_n), .addr_r(addr_r),
   .int_l_n(int_l_n), .int_r_n(int_r_n)
);

// File: tb/mbx_int_top_tb.sv
`timescale 1ns/1ps
module mbx_int_top_tb;
   localparam int AW = 15;
   localparam logic [AW-1:0] A_TOP   = 15'h7FFF;
   localparam logic [AW-1:0] A_NEXT  = 15'h7FFE;
   localparam logic [AW-1:0] A_OTHER = 15'h1234;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_l_n = 1, rw_l_n = 1, oe_l_n = 1, busy_l_n = 1;
   logic ce_r_n = 1, rw_r_n = 1, oe_r_n = 1, busy_r_n = 1;
   logic [AW-1:0] addr_l = '0, addr_r = '0;
   logic int_l_n, int_r_n;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   mbx_int_top #(.AW(AW)) u_dut (.*);

   // vector: {op[1:0], port, asel[1:0], busy_n, exp_l, exp_r}
   // op: 1 write, 2 read, 3 read with oe high; port 0 left, 1 right
   // asel: 0 top, 1 next, 2 ordinary address
   localparam int NV = 17;
   localparam logic [7:0] VEC [NV] = '{
      8'b01_0_00_1_10, // R1 left write top sets int_r
      8'b10_1_00_1_11, // R2 right read top clears
      8'b01_1_01_1_01, // R3 right write next sets int_l
      8'b10_0_01_1_11, // R4 left read next clears
      8'b01_0_00_0_11, // R5 busy suppresses set
      8'b01_0_10_1_11, // R9 ordinary address
      8'b01_0_00_1_10, // R1 set again
      8'b10_1_00_0_10, // R5 busy suppresses clear
      8'b11_1_00_1_10, // R9 oe high read
      8'b10_0_00_1_10, // R9 wrong port reads top
      8'b10_1_00_1_11, // R2 clear
      8'b01_1_00_1_11, // R9 right write top
      8'b01_0_01_1_11, // R9 left write next
      8'b01_1_01_1_01, // R3 set int_l
      8'b10_1_01_1_01, // R9 right read next
      8'b10_0_01_0_01, // R5 busy suppresses clear
      8'b10_0_01_1_11  // R4 clear
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input bit port, input logic ce, input logic rw, input logic oe,
                        input logic busy, input logic [AW-1:0] a);
      if (!port) begin ce_l_n = ce; rw_l_n = rw; oe_l_n = oe; busy_l_n = busy; addr_l = a; end
      else       begin ce_r_n = ce; rw_r_n = rw; oe_r_n = oe; busy_r_n = busy; addr_r = a; end
   endtask

   task automatic idle(input bit port);
      drive(port, 1'b1, 1'b1, 1'b1, 1'b1, '0);
   endtask

   function automatic logic [AW-1:0] pick(input logic [1:0] s);
      return (s == 2'd0) ? A_TOP : (s == 2'd1) ? A_NEXT : A_OTHER;
   endfunction

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset int_l", int_l_n, 1'b1);
      chk("R8 reset int_r", int_r_n, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 post-reset int_l", int_l_n, 1'b1);
      chk("R8 post-reset int_r", int_r_n, 1'b1);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] v;
         v = VEC[i];
         @(negedge clk);
         case (v[7:6])
            2'd1: drive(v[5], 1'b0, 1'b0, 1'b1, v[2], pick(v[4:3]));
            2'd2: drive(v[5], 1'b0, 1'b1, 1'b0, v[2], pick(v[4:3]));
            default: drive(v[5], 1'b0, 1'b1, 1'b1, v[2], pick(v[4:3]));
         endcase
         @(negedge clk);
         idle(v[5]);
         @(negedge clk);
         chk($sformatf("vec%0d int_l", i), int_l_n, v[1]);
         chk($sformatf("vec%0d int_r", i), int_r_n, v[0]);
      end

      // R6: held write does not set until it ends
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, A_TOP);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R6 held write int_r", int_r_n, 1'b1);
      end
      idle(1'b0);
      @(negedge clk);
      chk("R6 write end sets int_r", int_r_n, 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, A_TOP);
      @(negedge clk);
      idle(1'b1);
      chk("R2 clear after held write", int_r_n, 1'b1);

      // R1: address change ends the write
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, A_TOP);
      @(negedge clk);
      addr_l = A_OTHER;
      @(negedge clk);
      idle(1'b0);
      chk("R1 address change ends write", int_r_n, 1'b0);

      // R7: set and clear on the same edge, flag currently low
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, A_TOP);
      @(negedge clk);
      idle(1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, A_TOP);
      @(negedge clk);
      idle(1'b1);
      chk("R7 set wins (was low)", int_r_n, 1'b0);
      // clear, then same-edge collision from high
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, A_TOP);
      @(negedge clk);
      idle(1'b1);
      chk("R2 clear before collision", int_r_n, 1'b1);
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, A_NEXT);
      @(negedge clk);
      idle(1'b1);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, A_NEXT);
      @(negedge clk);
      idle(1'b0);
      chk("R7 set wins int_l", int_l_n, 1'b0);

      // R5: busy low in last write cycle suppresses
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, A_TOP);
      @(negedge clk);
      busy_l_n = 1'b0;
      @(negedge clk);
      idle(1'b0);
      @(negedge clk);
      chk("R5 busy at write end", int_r_n, 1'b1);

      // R8: reset mid-run returns flags high
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset clears int_l", int_l_n, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 after reset int_r", int_r_n, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule